// File: doc/BRIEF.md
# Filtered Pin-Change Interrupt Port

This block watches eight pins and raises a shared interrupt request when one of them makes a clean transition in a chosen direction. Each pin goes through a two-flop synchronizer and then a small digital pulse filter. The filter accepts an edge only when it sees a settled run of inactive-level samples followed by a settled run of active-level samples. Short glitches in either direction send the filter back to its start state.

Each accepted edge sets that pin's sticky flag. Software clears a flag by writing a one to it. A flag is set whether or not its pin is enabled, and whether the pin is used as an input or an output. The pin's enable decides only whether the flag drives the interrupt request.

The filters advance only on cycles where the sample strobe is high. That strobe stands in for either the bus clock or a slow low-power clock. The block also drives a request for that low-power sampling clock, and keeps it high only while some enabled, unflagged pin still has filtering work to do.

Top module: `pin_irq_port`

## Requirements
- R1: After reset, all flags, the enables and the polarities are zero, and `irqReq` and `sampleReq` are low.
- R2: A write with `wrAddr` = 0 loads the enables. `wrAddr` = 1 loads the polarities, where 1 makes the rising edge sensitive and 0 makes the falling edge sensitive. `wrAddr` = 2 clears the flags whose data bits are 1. `wrAddr` = 3 changes nothing.
- R3: A pin's flag is set after 4 consecutive strobed samples at the passive level followed by 4 consecutive strobed samples at the active level. The flag is visible the cycle after the fourth active sample. Pins pass through a two-stage synchronizer before sampling.
- R4: Any break in the sequence returns that pin's filter to its start state, with no samples counted. A break is an active sample before 4 passive samples, or a passive sample before 4 active samples. After a break the full 4+4 sequence is needed again.
- R5: The filters change state only on cycles where `sampleEn` is high. Level changes with no strobe set no flag.
- R6: A flag is set whether or not its pin is enabled. `irqReq` is the OR over all pins of flag AND enable.
- R7: Flag clear is write-1-to-clear. An edge accepted in the same cycle as a clear of that flag leaves the flag set, while other flags in the same write are cleared.
- R8: A polarity write that changes a pin's bit returns that pin's filter to its start state. Pins whose polarity bit is written with its old value keep their filter progress.
- R9: `sampleReq` is high when at least one pin has its enable set, its flag clear, and still needs sampling. A pin still needs sampling when its count is below 4, or when its synchronized level differs from the level its saturated count belongs to.
- R10: The count saturates at 4 in each phase. A long passive run followed by 4 active samples sets the flag. A long active run sets the flag only once, and after a clear the flag stays clear until a new passive run is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Raw pin levels |
| sampleEn | input | 1 | Filter sample strobe (bus or low-power clock tick) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Register write data, one bit per pin |
| pinFlags | output | 8 | Sticky per-pin edge flags |
| irqReq | output | 1 | Shared interrupt request |
| sampleReq | output | 1 | Request for the low-power sampling clock |

## Verification
A filter stuck in the wrong phase or count does not show at once. It shows at the fourth strobe of the next pin sequence, as a flag that rises one strobe early or late, or as a flag that never rises after a break. The same fault shows one cycle earlier on `sampleReq`, which drops exactly when a pin's count saturates with its level matching. For that reason the bench samples `sampleReq` between strobes as well as the flags. A wrong flag or enable register shows on `irqReq` in the cycle after the write.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_FLAGCLR  = 2'd2,
    REG_SPARE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadEnable;
    logic loadPolarity;
    logic clearFlags;
  } ctrlStrobe_t;
endpackage

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelIn,
  input  logic polarity,
  input  logic restart,
  input  logic sampleEn,
  output logic edgeHit,
  output logic needSample
);
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic             nPhase;
  logic [CNT_W-1:0] nCnt;
  logic             active;

  assign active = polarity ? levelIn : ~levelIn;

  always_comb begin
    nPhase  = phase;
    nCnt    = cnt;
    edgeHit = 1'b0;
    if (restart) begin
      nPhase = 1'b0;
      nCnt   = '0;
    end else if (sampleEn) begin
      if (!phase) begin
        if (!active) begin
          if (cnt != FULL) nCnt = cnt + ONE;
        end else if (cnt == FULL) begin
          nPhase = 1'b1;
          nCnt   = ONE;
        end else begin
          nCnt = '0;
        end
      end else begin
        if (active) begin
          if (cnt == LAST) begin
            edgeHit = 1'b1;
            nCnt    = FULL;
          end else if (cnt != FULL) begin
            nCnt = cnt + ONE;
          end
        end else if (cnt == FULL) begin
          nPhase = 1'b0;
          nCnt   = ONE;
        end else begin
          nPhase = 1'b0;
          nCnt   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      phase <= nPhase;
      cnt   <= nCnt;
    end
  end

  assign needSample = (cnt != FULL) || (active != phase);

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN) cnt <= FULL);

  // R8
  restart_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cnt == '0 && !phase));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrAddr)
        REG_ENABLE:   strobe.loadEnable   = 1'b1;
        REG_POLARITY: strobe.loadPolarity = 1'b1;
        REG_FLAGCLR:  strobe.clearFlags   = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadEnable, strobe.loadPolarity, strobe.clearFlags}));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe == '0));
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int RUN   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic             sampleEn,
  input  ctrlStrobe_t      strobe,
  input  logic [NPINS-1:0] wrData,
  output logic [NPINS-1:0] flags,
  output logic             irqReq,
  output logic             sampleReq
);
  logic [NPINS-1:0] syncA, syncB;
  logic [NPINS-1:0] enReg, polReg, flagReg;
  logic [NPINS-1:0] polChange, clrMask, edgeVec, needVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign polChange = strobe.loadPolarity ? (wrData ^ polReg) : '0;
  assign clrMask   = strobe.clearFlags ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      polReg  <= '0;
      flagReg <= '0;
    end else begin
      if (strobe.loadEnable)   enReg  <= wrData;
      if (strobe.loadPolarity) polReg <= wrData;
      flagReg <= (flagReg & ~clrMask) | edgeVec;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_irq_filter #(.RUN(RUN)) u_filter (
      .clk       (clk),
      .rstN      (rstN),
      .levelIn   (syncB[i]),
      .polarity  (polReg[i]),
      .restart   (polChange[i]),
      .sampleEn  (sampleEn),
      .edgeHit   (edgeVec[i]),
      .needSample(needVec[i])
    );

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagReg[i]) |-> $past(sampleEn));

    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagReg[i]) |-> $past(strobe.clearFlags && wrData[i]));
  end

  assign flags     = flagReg;
  assign irqReq    = |(flagReg & enReg);
  assign sampleReq = |(enReg & ~flagReg & needVec);

  // R9
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> (|(enReg & ~flagReg)));
endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int RUN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  pinIn,
  input  logic              sampleEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NPINS-1:0]  wrData,
  output logic [NPINS-1:0]  pinFlags,
  output logic              irqReq,
  output logic              sampleReq
);
  ctrlStrobe_t strobe;

  pin_irq_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .strobe(strobe)
  );

  pin_irq_datapath #(.NPINS(NPINS), .RUN(RUN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .sampleEn (sampleEn),
    .strobe   (strobe),
    .wrData   (wrData),
    .flags    (pinFlags),
    .irqReq   (irqReq),
    .sampleReq(sampleReq)
  );
endmodule

// File: tb/pin_irq_port_test.sv
module pin_irq_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic       sampleEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pinFlags;
  logic       irqReq, sampleReq;

  always #10 clk = ~clk;

  pin_irq_port uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .sampleEn(sampleEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinFlags(pinFlags), .irqReq(irqReq), .sampleReq(sampleReq)
  );

  typedef struct {
    logic [7:0] flags;
    logic       irq;
    logic       req;
    bit         reqCare;
    string      tag;
  } item_t;

  item_t q[$];
  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares away from the active edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        runCnt++;
        if (pinFlags !== it.flags || irqReq !== it.irq ||
            (it.reqCare && sampleReq !== it.req)) begin
          failCnt++;
          $display("FAIL %s: flags=%h irq=%b req=%b expected flags=%h irq=%b req=%b",
                   it.tag, pinFlags, irqReq, sampleReq, it.flags, it.irq, it.req);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input logic [7:0] f, input logic i, input logic r,
                            input bit rc, input string tag);
    item_t it;
    it.flags = f; it.irq = i; it.req = r; it.reqCare = rc; it.tag = tag;
    q.push_back(it);
    step();
  endtask

  task automatic setPins(input logic [7:0] v);
    pinIn = v;
    repeat (3) step();
  endtask

  task automatic samples(input int n);
    for (int k = 0; k < n; k++) begin
      sampleEn = 1'b1;
      step();
    end
    sampleEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) step();
    rstN = 1'b1;
    step();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failCnt++;
      runCnt++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    step();
    doReset();
    expect_out(8'h00, 1'b0, 1'b0, 1, "R1");

    regWrite(2'd1, 8'hFF);
    setPins(8'h00); samples(9);
    setPins(8'h01); samples(3);
    expect_out(8'h00, 1'b0, 1'b0, 1, "R3");
    samples(1);
    expect_out(8'h01, 1'b0, 1'b0, 1, "R3"); // also R6/R10: disabled, long passive run
    regWrite(2'd0, 8'h01);
    expect_out(8'h01, 1'b1, 1'b0, 1, "R6");
    regWrite(2'd3, 8'hFF);
    expect_out(8'h01, 1'b1, 1'b0, 1, "R2");
    regWrite(2'd2, 8'h01);
    expect_out(8'h00, 1'b0, 1'b0, 1, "R7");
    samples(6);
    expect_out(8'h00, 1'b0, 1'b0, 1, "R10");

    // R4: short passive run
    setPins(8'h00); samples(2);
    setPins(8'h01); samples(4);
    expect_out(8'h00, 1'b0, 1'b0, 0, "R4");
    setPins(8'h00); samples(4);
    setPins(8'h01); samples(4);
    expect_out(8'h01, 1'b1, 1'b0, 0, "R4");
    regWrite(2'd2, 8'h01);

    // R4: short active run, then short passive after break
    setPins(8'h00); samples(4);
    setPins(8'h01); samples(3);
    setPins(8'h00); samples(1); samples(3);
    setPins(8'h01); samples(4);
    expect_out(8'h00, 1'b0, 1'b0, 0, "R4");

    // R5
    setPins(8'h00); samples(4);
    setPins(8'h01); repeat (10) step();
    expect_out(8'h00, 1'b0, 1'b0, 0, "R5");
    samples(4);
    expect_out(8'h01, 1'b1, 1'b0, 0, "R5");
    regWrite(2'd2, 8'h01);

    // R8: unchanged polarity bit keeps progress
    regWrite(2'd1, 8'hFF);
    setPins(8'h03); samples(4);
    expect_out(8'h02, 1'b0, 1'b0, 0, "R8");
    regWrite(2'd2, 8'h02);
    setPins(8'h01); samples(4);
    regWrite(2'd1, 8'hFD);
    regWrite(2'd1, 8'hFF);
    setPins(8'h03); samples(4);
    expect_out(8'h00, 1'b0, 1'b0, 0, "R8");

    // R2: falling-edge polarity
    regWrite(2'd1, 8'hFD);
    samples(4);
    setPins(8'h01); samples(4);
    expect_out(8'h02, 1'b0, 1'b0, 0, "R2");

    // R7: edge and clear in the same cycle
    setPins(8'h05); samples(3);
    sampleEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h06;
    step();
    sampleEn = 1'b0; wrEn = 1'b0; wrData = '0;
    expect_out(8'h04, 1'b0, 1'b0, 0, "R7");
    regWrite(2'd0, 8'h04);
    expect_out(8'h04, 1'b1, 1'b0, 0, "R6");

    // R9: sampling clock request
    setPins(8'h00);
    doReset();
    expect_out(8'h00, 1'b0, 1'b0, 1, "R1");
    regWrite(2'd0, 8'h01);
    regWrite(2'd1, 8'h01);
    expect_out(8'h00, 1'b0, 1'b1, 1, "R9");
    samples(4);
    expect_out(8'h00, 1'b0, 1'b0, 1, "R9");
    setPins(8'h01);
    expect_out(8'h00, 1'b0, 1'b1, 1, "R9");
    samples(4);
    expect_out(8'h01, 1'b1, 1'b0, 1, "R9");
    regWrite(2'd2, 8'h01);
    expect_out(8'h00, 1'b0, 1'b0, 1, "R9");
    setPins(8'h00);
    expect_out(8'h00, 1'b0, 1'b1, 1, "R9");

    step();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule